// File: doc/BRIEF.md
# Split-Latency Integer Multiplier

This unit computes the four integer multiply operations of a 32-bit RISC-V core's M extension. It takes two operands, a two-bit operation code and a start strobe. It returns a registered 32-bit result together with a one-cycle valid pulse.

In its default split mode, the operands are cut into 16-bit halves, and only three narrow multipliers and one three-input 34-bit adder are built. A low-half product completes in one cycle. For a high-half product, the first cycle forms the low and cross partial products and keeps the carry-out part in an accumulator. The second cycle reuses one of the narrow multipliers for the upper halves and the same adder to fold in the accumulator. While that second cycle runs, the unit reports busy and ignores new requests.

A parameter selects an alternative wide mode instead. In that mode one 33-by-33 signed multiplier finishes every operation in one cycle.

Top module: `mul_split_unit`

## Requirements
- R1: With op code 2'b00 (MUL), a start accepted at a clock edge yields the low 32 bits of the product on `result_o` with `valid_o` high in the following cycle.
- R2: With op code 2'b01 (MULH), both operands are taken as signed, and the upper 32 bits of the 64-bit product appear with `valid_o` high two cycles after the accepting edge.
- R3: With op code 2'b10 (MULHSU), `a_i` is signed and `b_i` is unsigned, and the upper 32 bits appear two cycles after the accepting edge.
- R4: With op code 2'b11 (MULHU), both operands are unsigned, and the upper 32 bits appear two cycles after the accepting edge.
- R5: In split mode, `busy_o` is high for exactly the one cycle between the accepting edge of a high-half operation and its result, and `valid_o` is low in that cycle.
- R6: A start presented while `busy_o` is high is ignored. The pending result is unchanged, and no extra valid pulse follows.
- R7: `valid_o` is a single-cycle pulse. While no result is produced, `result_o` keeps its last value.
- R8: While `rst_n` is low, `result_o` is zero and `valid_o` and `busy_o` are low.
- R9: A start presented in the cycle in which a high-half result is valid is accepted, and its result follows with its own latency.
- R10: With `SPLIT_MODE` = 0, every operation's result is valid in the cycle after the accepting edge, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiply this cycle |
| op_i | input | 2 | Operation code (00 low, 01 signed high, 10 signed-by-unsigned high, 11 unsigned high) |
| a_i | input | DATA_W | First operand (rs1) |
| b_i | input | DATA_W | Second operand (rs2) |
| result_o | output | DATA_W | Registered result |
| valid_o | output | 1 | Result on `result_o` is new this cycle |
| busy_o | output | 1 | Second cycle of a high-half multiply in progress |

## Verification
Two functions can fall in the same cycle: the delivery of a high-half result and the acceptance of the next request. The first cycle of the new request then drives the shared multiplier and adder from the fresh operands, while the result register still shows the previous answer. The bench provokes this by raising start, with a low-half operation and different operands, exactly in the valid cycle of a MULHU. It judges both results against a 64-bit reference product: the MULHU value in that cycle, and the new low product one cycle later. A related overlap, a start raised during the busy cycle, is judged by checking that the pending result is unchanged and that no extra valid pulse follows.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    OP_MUL    = 2'b00,
    OP_MULH   = 2'b01,
    OP_MULHSU = 2'b10,
    OP_MULHU  = 2'b11
  } mul_op_e;

  // First operand is treated as signed for MULH and MULHSU
  function automatic logic op_a_signed(mul_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU);
  endfunction

  // Second operand is treated as signed only for MULH
  function automatic logic op_b_signed(mul_op_e op);
    return (op == OP_MULH);
  endfunction

endpackage

// File: rtl/mul_slice.sv
// Narrow multiplier: each operand is a half word with its own signedness control.
module mul_slice #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W + 2
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic              a_sgn_i,
  input  logic [HALF_W-1:0] b_i,
  input  logic              b_sgn_i,
  output logic [PROD_W-1:0] p_o
);
  logic signed [HALF_W:0]   a_x;
  logic signed [HALF_W:0]   b_x;
  logic signed [PROD_W-1:0] prod;

  assign a_x  = {a_sgn_i & a_i[HALF_W-1], a_i};
  assign b_x  = {b_sgn_i & b_i[HALF_W-1], b_i};
  assign prod = a_x * b_x;
  assign p_o  = prod;
endmodule

// File: rtl/mul_add3.sv
// Three-operand adder shared by both cycles of a high-half multiply.
module mul_add3 #(
  parameter int unsigned W = 34
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o
);
  assign s_o = x_i + y_i + z_i;
endmodule

// File: rtl/mul_split_unit.sv
module mul_split_unit
  import mul_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter bit          SPLIT_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned PROD_W = 2 * HALF_W + 2;
  localparam int unsigned ACC_W  = PROD_W - HALF_W;
  localparam int unsigned N_MUL  = 3;

  mul_op_e op;
  logic    a_sgn;
  logic    b_sgn;

  assign op    = mul_op_e'(op_i);
  assign a_sgn = op_a_signed(op);
  assign b_sgn = op_b_signed(op);

  logic              res_en;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              valid_d;
  logic              valid_q;

  generate
    if (SPLIT_MODE) begin : g_split
      typedef enum logic {ST_IDLE, ST_HIGH} st_e;

      st_e               st_q;
      st_e               st_d;
      logic              accept;
      logic              hold_en;
      logic [HALF_W-1:0] ah_q;
      logic [HALF_W-1:0] bh_q;
      logic              asg_q;
      logic              bsg_q;
      logic [ACC_W-1:0]  acc_q;
      logic [ACC_W-1:0]  acc_d;

      logic [HALF_W-1:0] sl_a   [N_MUL];
      logic [HALF_W-1:0] sl_b   [N_MUL];
      logic              sl_as  [N_MUL];
      logic              sl_bs  [N_MUL];
      logic [PROD_W-1:0] sl_p   [N_MUL];

      logic [PROD_W-1:0] add_x;
      logic [PROD_W-1:0] add_y;
      logic [PROD_W-1:0] add_z;
      logic [PROD_W-1:0] sum;

      assign accept  = start_i && (st_q == ST_IDLE);
      assign hold_en = accept && (op != OP_MUL);

      // Operand routing: first cycle low/cross terms, second cycle upper halves
      always_comb begin
        sl_a[0]  = a_i[HALF_W-1:0];
        sl_as[0] = 1'b0;
        sl_b[0]  = b_i[HALF_W-1:0];
        sl_bs[0] = 1'b0;
        if (st_q == ST_HIGH) begin
          sl_a[0]  = ah_q;
          sl_as[0] = asg_q;
          sl_b[0]  = bh_q;
          sl_bs[0] = bsg_q;
        end
        sl_a[1]  = a_i[HALF_W-1:0];
        sl_as[1] = 1'b0;
        sl_b[1]  = b_i[DATA_W-1:HALF_W];
        sl_bs[1] = b_sgn;
        sl_a[2]  = a_i[DATA_W-1:HALF_W];
        sl_as[2] = a_sgn;
        sl_b[2]  = b_i[HALF_W-1:0];
        sl_bs[2] = 1'b0;
      end

      for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        mul_slice #(.HALF_W(HALF_W)) u_slice (
          .a_i    (sl_a[g]),
          .a_sgn_i(sl_as[g]),
          .b_i    (sl_b[g]),
          .b_sgn_i(sl_bs[g]),
          .p_o    (sl_p[g])
        );
      end

      always_comb begin
        if (st_q == ST_HIGH) begin
          add_x = sl_p[0];
          add_y = {{(PROD_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
          add_z = '0;
        end else begin
          add_x = sl_p[1];
          add_y = sl_p[2];
          add_z = {{(PROD_W-HALF_W){1'b0}}, sl_p[0][2*HALF_W-1:HALF_W]};
        end
      end

      mul_add3 #(.W(PROD_W)) u_add (
        .x_i(add_x),
        .y_i(add_y),
        .z_i(add_z),
        .s_o(sum)
      );

      assign acc_d = sum[PROD_W-1:HALF_W];

      always_comb begin
        st_d    = st_q;
        res_en  = 1'b0;
        res_d   = {sum[HALF_W-1:0], sl_p[0][HALF_W-1:0]};
        unique case (st_q)
          ST_IDLE: begin
            if (accept && (op == OP_MUL)) res_en = 1'b1;
            if (hold_en)                  st_d   = ST_HIGH;
          end
          ST_HIGH: begin
            res_en = 1'b1;
            res_d  = sum[DATA_W-1:0];
            st_d   = ST_IDLE;
          end
          default: st_d = ST_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= ST_IDLE;
        end else begin
          st_q <= st_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ah_q  <= '0;
          bh_q  <= '0;
          asg_q <= 1'b0;
          bsg_q <= 1'b0;
          acc_q <= '0;
        end else if (hold_en) begin
          ah_q  <= a_i[DATA_W-1:HALF_W];
          bh_q  <= b_i[DATA_W-1:HALF_W];
          asg_q <= a_sgn;
          bsg_q <= b_sgn;
          acc_q <= acc_d;
        end
      end

      assign busy_o = (st_q == ST_HIGH);
    end else begin : g_wide
      logic signed [DATA_W:0]     wa;
      logic signed [DATA_W:0]     wb;
      logic signed [2*DATA_W+1:0] wp;

      assign wa     = {a_sgn & a_i[DATA_W-1], a_i};
      assign wb     = {b_sgn & b_i[DATA_W-1], b_i};
      assign wp     = wa * wb;
      assign res_en = start_i;
      assign res_d  = (op == OP_MUL) ? wp[DATA_W-1:0] : wp[2*DATA_W-1:DATA_W];
      assign busy_o = 1'b0;
    end
  endgenerate

  assign valid_d = res_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/mul_split_unit_chk.sv
module mul_split_unit_chk #(
  parameter bit          SPLIT  = 1'b1,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              busy_o
);
  p_mul_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_i == 2'b00) |=> valid_o);

  p_never_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && valid_o));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !busy_o) |=> (!valid_o && $stable(result_o)));

  generate
    if (SPLIT) begin : g_split_props
      p_high_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i != 2'b00) |=> (busy_o && !valid_o));

      p_high_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (valid_o && !busy_o));

      p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !busy_o);
    end else begin : g_wide_props
      p_wide_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && !busy_o));
    end
  endgenerate
endmodule

bind mul_split_unit mul_split_unit_chk #(.SPLIT(SPLIT_MODE), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_mul_split_unit.sv
module test_mul_split_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] res;
  logic        vld;
  logic        bsy;
  logic [31:0] w_res;
  logic        w_vld;
  logic        w_bsy;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  mul_split_unit #(.DATA_W(32), .SPLIT_MODE(1'b1)) i_mul_split_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .result_o(res), .valid_o(vld), .busy_o(bsy));

  mul_split_unit #(.DATA_W(32), .SPLIT_MODE(1'b0)) i_mul_split_unit_wide (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .result_o(w_res), .valid_o(w_vld), .busy_o(w_bsy));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_res(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    logic [63:0] xe;
    logic [63:0] ye;
    logic [63:0] p;
    xe = (o == 2'b01 || o == 2'b10) ? {{32{x[31]}}, x} : {32'h0, x};
    ye = (o == 2'b01) ? {{32{y[31]}}, y} : {32'h0, y};
    p  = xe * ye;
    return (o == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // Issue one operation and check both instances at the expected cycles
  task automatic run_op(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] e;
    e = expect_res(o, x, y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    chk("R10 wide valid", {31'b0, w_vld}, 32'd1);
    chk("R10 wide result", w_res, e);
    chk("R10 wide busy", {31'b0, w_bsy}, 32'd0);
    if (o == 2'b00) begin
      chk("R1 valid", {31'b0, vld}, 32'd1);
      chk("R1 result", res, e);
    end else begin
      chk("R5 busy", {31'b0, bsy}, 32'd1);
      chk("R5 valid low while busy", {31'b0, vld}, 32'd0);
      @(negedge clk);
      chk({req_of(o), " valid"}, {31'b0, vld}, 32'd1);
      chk({req_of(o), " result"}, res, e);
      chk("R5 busy dropped", {31'b0, bsy}, 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; op = 2'b00; a = '0; b = '0;
    repeat (2) @(negedge clk);
    chk("R8 result", res, 32'h0);
    chk("R8 valid", {31'b0, vld}, 32'd0);
    chk("R8 busy", {31'b0, bsy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_corners();
    logic [31:0] cv [6];
    cv[0] = 32'h0; cv[1] = 32'hFFFF_FFFF; cv[2] = 32'h8000_0000;
    cv[3] = 32'h7FFF_FFFF; cv[4] = 32'h0000_FFFF; cv[5] = 32'h0001_0000;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int o = 0; o < 4; o++)
          run_op(2'(o), cv[i], cv[j]);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++)
      for (int o = 0; o < 4; o++)
        run_op(2'(o), $urandom, $urandom);
  endtask

  task automatic t_hold();
    logic [31:0] last;
    run_op(2'b00, 32'h1234_5678, 32'h9ABC_DEF0);
    last = res;
    @(negedge clk);
    chk("R7 valid pulse ends", {31'b0, vld}, 32'd0);
    chk("R7 result held", res, last);
    @(negedge clk);
    chk("R7 result still held", res, last);
  endtask

  task automatic t_ignore();
    logic [31:0] e;
    e = expect_res(2'b01, 32'hDEAD_BEEF, 32'h8765_4321);
    @(negedge clk);
    start = 1'b1; op = 2'b01; a = 32'hDEAD_BEEF; b = 32'h8765_4321;
    @(negedge clk);
    chk("R6 busy", {31'b0, bsy}, 32'd1);
    op = 2'b00; a = 32'h1111_1111; b = 32'h2222_2222;
    @(negedge clk);
    start = 1'b0;
    chk("R6 pending result kept", res, e);
    chk("R6 valid", {31'b0, vld}, 32'd1);
    @(negedge clk);
    chk("R6 no extra valid", {31'b0, vld}, 32'd0);
    chk("R6 result unchanged", res, e);
  endtask

  task automatic t_back_to_back();
    logic [31:0] e1;
    logic [31:0] e2;
    e1 = expect_res(2'b11, 32'hFFFF_0001, 32'hC000_0003);
    e2 = expect_res(2'b00, 32'h0BAD_F00D, 32'h7654_3210);
    @(negedge clk);
    start = 1'b1; op = 2'b11; a = 32'hFFFF_0001; b = 32'hC000_0003;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 first result", res, e1);
    chk("R9 first valid", {31'b0, vld}, 32'd1);
    start = 1'b1; op = 2'b00; a = 32'h0BAD_F00D; b = 32'h7654_3210;
    @(negedge clk);
    start = 1'b0;
    chk("R9 second result", res, e2);
    chk("R9 second valid", {31'b0, vld}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_hold();
    t_ignore();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule